// File: doc/BRIEF.md
# Lockable Configuration Store with User Signature

This block holds the configuration pattern of a programmable logic fabric as an array of fuse words. Beside that array it keeps a 64-bit user signature of eight bytes and one fabric state register that can be forced to a known value for test. A single command port takes one command per accepted cycle. The commands program a fuse word, read a word back, force the fabric register, write or read a signature byte, set the security lock, and erase the whole pattern.

The security lock takes effect on the edge that accepts it. From then on, fuse readback gives zero data with an error flag, and forcing the fabric register and programming fuses are refused with an error flag. Signature reads and writes keep working. Only the erase command releases the lock, and it also clears every fuse word. Because the lock acts at once, it has to be the last command in a programming sequence.

The command logic is a two-state machine. The state `ST_IDLE` accepts commands. The state `ST_BUSY` holds off new commands for a fixed count of cycles. The transition IDLE to BUSY fires when a program, signature-write, lock or erase command is accepted. The transition BUSY to IDLE fires when the hold counter reaches its last cycle. A command that is valid while busy is dropped without a response and without any effect.

Top module: `cfg_lock_store`

## Requirements
- R1: After reset, `busy`, `rsp_valid`, `rsp_err`, `rsp_data` and `fab_q` are zero, the lock is clear, and every fuse word and signature byte reads zero.
- R2: An accepted program command (`cmd_op`=1) stores `cmd_wdata` into fuse word `cmd_addr` while unlocked. An accepted verify command (`cmd_op`=2) returns that word on `rsp_data` with `rsp_err`=0 while unlocked.
- R3: A verify command accepted while locked returns `rsp_data`=0 with `rsp_err`=1.
- R4: A preload command (`cmd_op`=3) accepted while unlocked loads `cmd_wdata` into `fab_q`, visible one cycle after acceptance. While locked, `fab_q` stays unchanged and `rsp_err`=1.
- R5: A signature write (`cmd_op`=4) stores `cmd_wdata[7:0]` into byte `cmd_addr[2:0]`. A signature read (`cmd_op`=5) returns that byte zero-extended on `rsp_data`. Both work the same whether or not the lock is set.
- R6: A lock command (`cmd_op`=6) sets the lock on its accepting edge, and the lock stays set through every command except erase. A program command accepted while locked is refused with `rsp_err`=1 and starts no busy period.
- R7: An erase command (`cmd_op`=7) clears every fuse word and the lock and leaves the signature bytes intact.
- R8: After an accepted signature write, lock, erase, or unlocked program, `busy` is high for exactly `BUSY_CYCLES` cycles starting the cycle after acceptance. Commands presented while `busy` is high are ignored.
- R9: Every accepted command except NOP (`cmd_op`=0) gives a one-cycle `rsp_valid` pulse in the cycle after acceptance. Responses that carry no read data have `rsp_data`=0. NOP gives no response and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (see R2 to R9) |
| cmd_addr | input | ADDR_W | Fuse word address; low 3 bits select the signature byte |
| cmd_wdata | input | DATA_W | Write data for program, preload and signature write |
| busy | output | 1 | Hold-off period active; commands ignored |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_err | output | 1 | Command refused because of the lock |
| rsp_data | output | DATA_W | Read data of verify or signature read |
| fab_q | output | DATA_W | Fabric state register, forced by preload |

## Verification
The assertions check several properties on every cycle. The lock stays set unless an erase arrives. An erase leaves the lock clear and the array zero. A refused program or preload leaves the fuse array and `fab_q` untouched. An error response never carries data. No response follows a busy cycle. The hold counter stays inside its range. Other behaviour needs the bench's scenarios to show it: the value returned by readback, a signature that survives locking and erasing, the exact length of a busy window, and a command dropped inside that window.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_PROG    = 3'd1,
        OP_VERIFY  = 3'd2,
        OP_PRELOAD = 3'd3,
        OP_SIG_WR  = 3'd4,
        OP_SIG_RD  = 3'd5,
        OP_LOCK    = 3'd6,
        OP_ERASE   = 3'd7
    } cfg_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } cfg_state_e;

    localparam int SIG_BYTES = 8;
    localparam int SIG_IDX_W = $clog2(SIG_BYTES);

endpackage

// File: rtl/cfg_cmd_fsm.sv
module cfg_cmd_fsm
    import cfg_store_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cmd_valid_i,
    input  cfg_op_e op_i,
    input  logic    secured_i,
    output logic    accept_o,
    output logic    busy_o
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    cfg_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             long_op;

    // Commands that occupy the store for a hold-off period
    always_comb begin
        long_op = (op_i == OP_SIG_WR) || (op_i == OP_LOCK) || (op_i == OP_ERASE) ||
                  ((op_i == OP_PROG) && !secured_i);
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid_i && long_op) begin
                    state_d = ST_BUSY;
                    cnt_d   = CNT_W'(BUSY_CYCLES);
                end
            end
            ST_BUSY: begin
                if (cnt_q == CNT_W'(1)) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        accept_o = cmd_valid_i && (state_q == ST_IDLE);
        busy_o   = (state_q == ST_BUSY);
    end

    // R8: hold counter stays within its window while busy
    p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY) |-> (cnt_q >= CNT_W'(1)) && (cnt_q <= CNT_W'(BUSY_CYCLES)));

    // R8: a busy period always starts with the full count
    p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (cnt_q == CNT_W'(BUSY_CYCLES)));

endmodule

// File: rtl/cfg_fuse_bank.sv
module cfg_fuse_bank #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     prog_en_i,
    input  logic                     lock_en_i,
    input  logic                     erase_en_i,
    input  logic [$clog2(DEPTH)-1:0] addr_i,
    input  logic [W-1:0]             wdata_i,
    output logic [W-1:0]             rdata_o,
    output logic                     secured_o
);
    localparam int AW = $clog2(DEPTH);

    logic [DEPTH-1:0][W-1:0] fuse_q;
    logic                    secured_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fuse_q    <= '0;
            secured_q <= 1'b0;
        end else if (erase_en_i) begin
            fuse_q    <= '0;
            secured_q <= 1'b0;
        end else begin
            if (lock_en_i) begin
                secured_q <= 1'b1;
            end
            for (int i = 0; i < DEPTH; i++) begin
                if (prog_en_i && !secured_q && (addr_i == AW'(i))) begin
                    fuse_q[i] <= wdata_i;
                end
            end
        end
    end

    always_comb begin
        rdata_o   = fuse_q[addr_i];
        secured_o = secured_q;
    end

    // R6: lock is sticky unless erased
    p_sticky_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (secured_q && !erase_en_i) |=> secured_q);

    // R6: programming under lock changes nothing
    p_prog_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en_i && secured_q && !erase_en_i) |=> $stable(fuse_q));

    // R7: erase clears array and lock
    p_erase_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en_i |=> (!secured_q && (fuse_q == '0)));

endmodule

// File: rtl/cfg_sig_bytes.sv
module cfg_sig_bytes
    import cfg_store_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [SIG_IDX_W-1:0] idx_i,
    input  logic [7:0]           wdata_i,
    output logic [7:0]           rdata_o
);
    logic [SIG_BYTES-1:0][7:0] sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= '0;
        end else if (wr_en_i) begin
            sig_q[idx_i] <= wdata_i;
        end
    end

    always_comb rdata_o = sig_q[idx_i];

    // R5: signature changes only through its own write strobe
    p_sig_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(sig_q));

endmodule

// File: rtl/cfg_lock_store.sv
module cfg_lock_store
    import cfg_store_pkg::*;
#(
    parameter int FUSE_DEPTH  = 16,
    parameter int DATA_W      = 8,
    parameter int BUSY_CYCLES = 4,
    localparam int ADDR_W     = $clog2(FUSE_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_data,
    output logic [DATA_W-1:0] fab_q
);
    cfg_op_e           op;
    logic              accept;
    logic              secured;
    logic [DATA_W-1:0] fuse_rdata;
    logic [7:0]        sig_rdata;
    logic              rsp_valid_q, rsp_err_q;
    logic [DATA_W-1:0] rsp_data_q, fab_q_r;

    always_comb op = cfg_op_e'(cmd_op);

    cfg_cmd_fsm #(.BUSY_CYCLES(BUSY_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid_i(cmd_valid),
        .op_i       (op),
        .secured_i  (secured),
        .accept_o   (accept),
        .busy_o     (busy)
    );

    cfg_fuse_bank #(.DEPTH(FUSE_DEPTH), .W(DATA_W)) u_fuse (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en_i (accept && (op == OP_PROG)),
        .lock_en_i (accept && (op == OP_LOCK)),
        .erase_en_i(accept && (op == OP_ERASE)),
        .addr_i    (cmd_addr),
        .wdata_i   (cmd_wdata),
        .rdata_o   (fuse_rdata),
        .secured_o (secured)
    );

    cfg_sig_bytes u_sig (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en_i(accept && (op == OP_SIG_WR)),
        .idx_i  (cmd_addr[SIG_IDX_W-1:0]),
        .wdata_i(cmd_wdata[7:0]),
        .rdata_o(sig_rdata)
    );

    // Response and fabric register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_data_q  <= '0;
            fab_q_r     <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_data_q  <= '0;
            if (accept) begin
                unique case (op)
                    OP_NOP: ;
                    OP_VERIFY: begin
                        rsp_valid_q <= 1'b1;
                        rsp_err_q   <= secured;
                        rsp_data_q  <= secured ? '0 : fuse_rdata;
                    end
                    OP_PRELOAD: begin
                        rsp_valid_q <= 1'b1;
                        rsp_err_q   <= secured;
                        if (!secured) fab_q_r <= cmd_wdata;
                    end
                    OP_PROG: begin
                        rsp_valid_q <= 1'b1;
                        rsp_err_q   <= secured;
                    end
                    OP_SIG_RD: begin
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= DATA_W'(sig_rdata);
                    end
                    OP_SIG_WR, OP_LOCK, OP_ERASE: begin
                        rsp_valid_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rsp_valid = rsp_valid_q;
        rsp_err   = rsp_err_q;
        rsp_data  = rsp_data_q;
        fab_q     = fab_q_r;
    end

    // R8: nothing is answered for a command offered while busy
    p_busy_no_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rsp_valid_q);

    // R3: a refused command never leaks data
    p_err_no_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err_q |-> (rsp_valid_q && (rsp_data_q == '0)));

    // R4: preload under lock leaves the fabric register alone
    p_preload_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op == OP_PRELOAD) && secured) |=> $stable(fab_q_r));

    // R9: NOP produces no response
    p_nop_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op == OP_NOP)) |=> !rsp_valid_q);

endmodule

// File: tb/cfg_lock_store_tb.sv
module cfg_lock_store_tb;
    localparam int FUSE_DEPTH  = 16;
    localparam int DATA_W      = 8;
    localparam int BUSY_CYCLES = 4;
    localparam int ADDR_W      = $clog2(FUSE_DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [DATA_W-1:0] cmd_wdata = '0;
    logic              busy, rsp_valid, rsp_err;
    logic [DATA_W-1:0] rsp_data, fab_q;

    always #5 clk = ~clk;

    cfg_lock_store #(.FUSE_DEPTH(FUSE_DEPTH), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data), .fab_q(fab_q)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Reference model
    logic [DATA_W-1:0] m_fuse [FUSE_DEPTH];
    logic [7:0]        m_sig [8];
    logic              m_lock;
    logic [DATA_W-1:0] m_fab;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_valid(input logic [2:0] op);
        return op != 3'd0;
    endfunction

    function automatic bit exp_err(input logic [2:0] op);
        return m_lock && (op == 3'd1 || op == 3'd2 || op == 3'd3);
    endfunction

    function automatic logic [DATA_W-1:0] exp_data(input logic [2:0] op, input logic [ADDR_W-1:0] a);
        if (op == 3'd2) return m_lock ? '0 : m_fuse[a];
        if (op == 3'd5) return DATA_W'(m_sig[a[2:0]]);
        return '0;
    endfunction

    function automatic int exp_busy(input logic [2:0] op);
        if (op == 3'd4 || op == 3'd6 || op == 3'd7 || (op == 3'd1 && !m_lock)) return BUSY_CYCLES;
        return 0;
    endfunction

    task automatic model_update(input logic [2:0] op, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        case (op)
            3'd1: if (!m_lock) m_fuse[a] = d;
            3'd3: if (!m_lock) m_fab = d;
            3'd4: m_sig[a[2:0]] = d[7:0];
            3'd6: m_lock = 1'b1;
            3'd7: begin
                m_lock = 1'b0;
                for (int i = 0; i < FUSE_DEPTH; i++) m_fuse[i] = '0;
            end
            default: ;
        endcase
    endtask

    // Issue one command, check its response and busy window.
    // probe=1 offers a conflicting signature write while busy (R8).
    task automatic issue(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d, input bit probe);
        logic [DATA_W-1:0] ed;
        bit ee, ev;
        int eb, cnt;
        ev = exp_valid(op);
        ee = exp_err(op);
        ed = exp_data(op, a);
        eb = exp_busy(op);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        @(posedge clk);
        model_update(op, a, d);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(rsp_valid == ev, "R9 rsp_valid", 64'(rsp_valid), 64'(ev));
        if (ev) begin
            chk(rsp_err == ee, (op == 3'd2) ? "R3 rsp_err" : "R6 rsp_err", 64'(rsp_err), 64'(ee));
            chk(rsp_data == ed, (op == 3'd5) ? "R5 rsp_data" : "R2 rsp_data", 64'(rsp_data), 64'(ed));
        end
        chk(fab_q == m_fab, "R4 fab_q", 64'(fab_q), 64'(m_fab));
        cnt = 0;
        while (busy && cnt < BUSY_CYCLES + 4) begin
            cnt++;
            if (probe && cnt == 1) begin
                cmd_valid = 1'b1; cmd_op = 3'd4; cmd_addr = a; cmd_wdata = ~d;
            end
            @(negedge clk);
            if (probe && cnt == 1) begin
                cmd_valid = 1'b0;
                chk(rsp_valid == 1'b0, "R8 ignored rsp", 64'(rsp_valid), 64'd0);
            end
        end
        chk(cnt == eb, "R8 busy length", 64'(cnt), 64'(eb));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [2:0] op;
        void'($urandom(32'd20240917));
        m_lock = 1'b0; m_fab = '0;
        for (int i = 0; i < FUSE_DEPTH; i++) m_fuse[i] = '0;
        for (int i = 0; i < 8; i++) m_sig[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 0 && rsp_valid == 0 && rsp_err == 0 && rsp_data == 0, "R1 outputs",
            {busy, rsp_valid, rsp_err, rsp_data}, 64'd0);
        chk(fab_q == 0, "R1 fab_q", 64'(fab_q), 64'd0);
        rst_n = 1'b1;
        issue(3'd2, 4'd5, '0, 0);          // R1 fuse word zero
        issue(3'd5, 4'd3, '0, 0);          // R1 signature zero
        // R2: program and read back, highest and lowest address
        issue(3'd1, 4'd15, 8'hA5, 0);
        issue(3'd1, 4'd0, 8'h3C, 0);
        issue(3'd2, 4'd15, '0, 0);
        issue(3'd2, 4'd0, '0, 0);
        // R4: preload while unlocked
        issue(3'd3, 4'd0, 8'h5A, 0);
        // R9: NOP silent
        issue(3'd0, 4'd1, 8'hFF, 0);
        // R5 / R8: signature write with dropped write during busy
        issue(3'd4, 4'd7, 8'hC3, 1);
        issue(3'd5, 4'd7, '0, 0);
        // R6: lock, then refused verify, preload, program
        issue(3'd6, 4'd0, '0, 0);
        issue(3'd2, 4'd15, '0, 0);        // R3
        issue(3'd3, 4'd0, 8'h11, 0);       // R4 refused
        issue(3'd1, 4'd2, 8'h77, 0);       // R6 refused, no busy
        // R5: signature under lock
        issue(3'd4, 4'd2, 8'h9E, 0);
        issue(3'd5, 4'd2, '0, 0);
        issue(3'd5, 4'd7, '0, 0);
        // R7: erase clears lock and fuses, keeps signature
        issue(3'd7, 4'd0, '0, 0);
        issue(3'd2, 4'd15, '0, 0);
        issue(3'd5, 4'd2, '0, 0);
        issue(3'd3, 4'd0, 8'h22, 0);
        // Random mix
        for (int k = 0; k < 400; k++) begin
            int r;
            r = int'($urandom % 16);
            case (r)
                0, 1, 2:  op = 3'd1;
                3, 4, 5, 15: op = 3'd2;
                6, 7:     op = 3'd3;
                8, 9:     op = 3'd4;
                10, 11:   op = 3'd5;
                12:       op = 3'd0;
                13:       op = 3'd6;
                default:  op = 3'd7;
            endcase
            issue(op, ADDR_W'($urandom), DATA_W'($urandom), ($urandom % 8) == 0);
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule